// File: doc/BRIEF.md
# Clean-Victim Copy-Back Predictor

This block sits beside one set-associative cache level and decides, for every clean line that leaves the cache, whether the line should be copied into the next cache level or dropped. It keeps its own metadata for every line: a 4-bit reuse-distance counter, a 2-bit hit counter, a prefetch flag and a valid bit. It also keeps a set-level reuse distance for each set, which is refreshed once per epoch of eight hits to that set. The tag and data arrays, the writeback path for dirty lines and the next cache level are outside the block.

The cache controller reports one access event per cycle on the access port. An event is a hit naming a way, a miss in a set, or a fill naming a way with a prefetch flag. On the eviction port it names the victim's set and way and says whether the victim is dirty. One cycle later the block returns a decision strobe. The strobe carries a copy or drop verdict and the priority score behind it.

The score is a sum of four terms. The first two flag lines that came in by prefetch and lines that saw few hits. The other two compare the line's reuse distance against twice and three times the set-level distance. A clean victim is copied only when its score stays under a threshold. A small two-state machine produces the strobe. `DEC_IDLE` moves to `DEC_EMIT` on an eviction request (transition *request*). `DEC_EMIT` stays in `DEC_EMIT` on a back-to-back request (transition *chain*). `DEC_EMIT` returns to `DEC_IDLE` when no request is present (transition *release*).

Top module: `clean_copyback_predictor`

## Requirements
- R1: Each valid line's reuse-distance counter increases by one on every miss event in its set and saturates at 15. It clears to 0 when that line hits and when that line is filled.
- R2: Each line's hit counter counts hit events to that line, saturates at 3 and clears to 0 on a fill of that line.
- R3: Each set keeps an accumulator of the pre-hit reuse distance of every line that hits in the set. On every 8th hit to the set, the set-level distance becomes (accumulator + this hit's distance) / 8, and the accumulator and the hit tally restart. Before the 8th hit the set-level distance does not change.
- R4: The victim's score is the sum of +1 if the line was filled as a prefetch, +1 if its hit count is 0 or 1, +8 if its distance is greater than 3 × set-level distance, and +4 if its distance is at least 2 × set-level distance. The comparisons are computed without overflow. `dec_score` reports the sum.
- R5: A clean victim is copied (`dec_copy`=1) only when its score is strictly below 9. Otherwise it is dropped (`dec_copy`=0).
- R6: A dirty victim always gives `dec_copy`=1, whatever its score.
- R7: `dec_valid` rises exactly one cycle after each eviction request, lasts one cycle per request, and is low otherwise.
- R8: An eviction scores the metadata as it stood before any access in the same cycle. An evicted line becomes invalid, and later misses do not advance its counter. A fill to the same way in the same cycle as its eviction leaves the line valid and freshly cleared.
- R9: After reset `dec_valid` is 0, every line is invalid with all counters and flags at 0, and every set-level distance is 0.
- Access encoding on `acc_kind`: 0 = hit (`acc_way` names the line), 1 = miss (`acc_way` ignored), 2 = fill (`acc_way` and `acc_prefetch` used), 3 = no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access event present this cycle |
| acc_kind | input | 2 | Access type: 0 hit, 1 miss, 2 fill, 3 none |
| acc_set | input | 4 | Set of the access |
| acc_way | input | 2 | Way of a hit or fill |
| acc_prefetch | input | 1 | Fill was triggered by a prefetch |
| evict_valid | input | 1 | Eviction request present this cycle |
| evict_set | input | 4 | Set of the victim |
| evict_way | input | 2 | Way of the victim |
| evict_dirty | input | 1 | Victim holds modified data |
| dec_valid | output | 1 | Decision strobe, one cycle per request |
| dec_copy | output | 1 | 1 = copy to next level, 0 = drop |
| dec_score | output | 4 | Priority score of the victim |

## Verification
An eviction and an access event can arrive in the same cycle and touch the same set. The bench provokes this in two ways. In the first, a miss lands in the cycle that a line at distance 6 is evicted. In the second, a fill lands on the very way being evicted. For the concurrent miss, the returned score must match the pre-miss distance of 6 (score 5), not 7 (score 13). Further misses must leave the invalidated victim's counter unchanged, which a second eviction of that line shows. For the concurrent fill, a later eviction after five misses must show the refilled line advancing to distance 5, which proves the fill won over the invalidation.

// File: rtl/ccbp_pkg.sv
package ccbp_pkg;

    localparam int RD_W    = 4;
    localparam int HIT_W   = 2;
    localparam int SCORE_W = 4;

    localparam int W_PREFETCH = 1;
    localparam int W_LOW_HITS = 1;
    localparam int W_FAR      = 8;
    localparam int W_MID      = 4;
    localparam int SCORE_MAX  = W_PREFETCH + W_LOW_HITS + W_FAR + W_MID;

    typedef enum logic [1:0] {
        ACC_HIT  = 2'd0,
        ACC_MISS = 2'd1,
        ACC_FILL = 2'd2,
        ACC_NONE = 2'd3
    } acc_kind_t;

    typedef enum logic {
        DEC_IDLE = 1'b0,
        DEC_EMIT = 1'b1
    } dec_state_t;

    typedef struct packed {
        logic              valid;
        logic              pf;
        logic [HIT_W-1:0]  hits;
        logic [RD_W-1:0]   rd;
    } line_meta_t;

endpackage

// File: rtl/ccbp_line_meta.sv
module ccbp_line_meta
    import ccbp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fill_i,
    input  logic       pf_i,
    input  logic       hit_i,
    input  logic       miss_i,
    input  logic       evict_i,
    output line_meta_t meta_o
);

    localparam logic [RD_W-1:0]  RD_TOP  = '1;
    localparam logic [HIT_W-1:0] HIT_TOP = '1;

    line_meta_t meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
        end else if (fill_i) begin
            meta_q.valid <= 1'b1;
            meta_q.pf    <= pf_i;
            meta_q.hits  <= '0;
            meta_q.rd    <= '0;
        end else begin
            if (evict_i) begin
                meta_q.valid <= 1'b0;
            end
            if (hit_i) begin
                meta_q.rd <= '0;
                if (meta_q.hits != HIT_TOP) begin
                    meta_q.hits <= meta_q.hits + HIT_W'(1);
                end
            end else if (miss_i && meta_q.valid && meta_q.rd != RD_TOP) begin
                meta_q.rd <= meta_q.rd + RD_W'(1);
            end
        end
    end

    assign meta_o = meta_q;

    AST_FILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_i |=> (meta_q.rd == '0 && meta_q.hits == '0 && meta_q.valid)); // R1

    AST_RD_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (meta_q.rd == RD_TOP && !fill_i && !hit_i) |=> meta_q.rd == RD_TOP); // R1

    AST_RD_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (meta_q.valid && miss_i && !fill_i && !hit_i && meta_q.rd != RD_TOP)
        |=> meta_q.rd == $past(meta_q.rd) + RD_W'(1)); // R1

    AST_HITS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (meta_q.hits == HIT_TOP && !fill_i) |=> meta_q.hits == HIT_TOP); // R2

    AST_INVALID_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!meta_q.valid && !fill_i && !hit_i) |=> $stable(meta_q.rd)); // R8

endmodule

// File: rtl/ccbp_set_epoch.sv
module ccbp_set_epoch
    import ccbp_pkg::*;
#(
    parameter int EPOCH_HITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit_i,
    input  logic [RD_W-1:0] hit_rd_i,
    output logic [RD_W-1:0] set_rd_o
);

    localparam int EPOCH_LOG2 = $clog2(EPOCH_HITS);
    localparam int ACC_W      = RD_W + EPOCH_LOG2;
    localparam logic [EPOCH_LOG2-1:0] LAST_HIT = EPOCH_LOG2'(EPOCH_HITS - 1);

    logic [ACC_W-1:0]      acc_q;
    logic [EPOCH_LOG2-1:0] tally_q;
    logic [RD_W-1:0]       set_rd_q;
    logic [ACC_W-1:0]      sum;

    always_comb begin
        sum = acc_q + ACC_W'(hit_rd_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            tally_q  <= '0;
            set_rd_q <= '0;
        end else if (hit_i) begin
            if (tally_q == LAST_HIT) begin
                set_rd_q <= RD_W'(sum >> EPOCH_LOG2);
                acc_q    <= '0;
                tally_q  <= '0;
            end else begin
                acc_q    <= sum;
                tally_q  <= tally_q + EPOCH_LOG2'(1);
            end
        end
    end

    assign set_rd_o = set_rd_q;

    AST_SETRD_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_i |=> $stable(set_rd_q)); // R3

    AST_SETRD_HOLD_MIDEPOCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && tally_q != LAST_HIT) |=> $stable(set_rd_q)); // R3

    AST_EPOCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && tally_q == LAST_HIT) |=> (acc_q == '0 && tally_q == '0)); // R3

endmodule

// File: rtl/ccbp_score.sv
module ccbp_score
    import ccbp_pkg::*;
#(
    parameter int COPY_THRESH = 9
) (
    input  line_meta_t         meta_i,
    input  logic [RD_W-1:0]    set_rd_i,
    input  logic               dirty_i,
    output logic [SCORE_W-1:0] score_o,
    output logic               copy_o
);

    localparam int MW = RD_W + 2;

    logic [MW-1:0]      rd_x;
    logic [MW-1:0]      twice;
    logic [MW-1:0]      thrice;
    logic [SCORE_W-1:0] total;

    always_comb begin
        rd_x   = MW'(meta_i.rd);
        twice  = MW'({set_rd_i, 1'b0});
        thrice = twice + MW'(set_rd_i);

        total = '0;
        if (meta_i.pf) begin
            total = total + SCORE_W'(W_PREFETCH);
        end
        if (meta_i.hits <= HIT_W'(1)) begin
            total = total + SCORE_W'(W_LOW_HITS);
        end
        if (rd_x > thrice) begin
            total = total + SCORE_W'(W_FAR);
        end
        if (rd_x >= twice) begin
            total = total + SCORE_W'(W_MID);
        end

        score_o = total;
        copy_o  = dirty_i || (total < SCORE_W'(COPY_THRESH));
    end

endmodule

// File: rtl/clean_copyback_predictor.sv
module clean_copyback_predictor
    import ccbp_pkg::*;
#(
    parameter int NUM_SETS    = 16,
    parameter int NUM_WAYS    = 4,
    parameter int EPOCH_HITS  = 8,
    parameter int COPY_THRESH = 9,
    localparam int SET_W      = $clog2(NUM_SETS),
    localparam int WAY_W      = $clog2(NUM_WAYS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [1:0]         acc_kind,
    input  logic [SET_W-1:0]   acc_set,
    input  logic [WAY_W-1:0]   acc_way,
    input  logic               acc_prefetch,
    input  logic               evict_valid,
    input  logic [SET_W-1:0]   evict_set,
    input  logic [WAY_W-1:0]   evict_way,
    input  logic               evict_dirty,
    output logic               dec_valid,
    output logic               dec_copy,
    output logic [SCORE_W-1:0] dec_score
);

    acc_kind_t kind;
    assign kind = acc_kind_t'(acc_kind);

    logic is_hit, is_miss, is_fill;
    assign is_hit  = acc_valid && (kind == ACC_HIT);
    assign is_miss = acc_valid && (kind == ACC_MISS);
    assign is_fill = acc_valid && (kind == ACC_FILL);

    line_meta_t      meta   [NUM_SETS][NUM_WAYS];
    logic [RD_W-1:0] set_rd [NUM_SETS];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic set_sel;
        assign set_sel = (acc_set == SET_W'(s));

        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            logic way_sel, victim_sel;
            assign way_sel    = set_sel && (acc_way == WAY_W'(w));
            assign victim_sel = evict_valid && (evict_set == SET_W'(s))
                                && (evict_way == WAY_W'(w));

            ccbp_line_meta u_line (
                .clk    (clk),
                .rst_n  (rst_n),
                .fill_i (is_fill && way_sel),
                .pf_i   (acc_prefetch),
                .hit_i  (is_hit && way_sel),
                .miss_i (is_miss && set_sel),
                .evict_i(victim_sel),
                .meta_o (meta[s][w])
            );
        end

        ccbp_set_epoch #(
            .EPOCH_HITS(EPOCH_HITS)
        ) u_epoch (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit_i   (is_hit && set_sel),
            .hit_rd_i(meta[s][acc_way].rd),
            .set_rd_o(set_rd[s])
        );
    end

    logic [SCORE_W-1:0] score_c;
    logic               copy_c;

    ccbp_score #(
        .COPY_THRESH(COPY_THRESH)
    ) u_score (
        .meta_i  (meta[evict_set][evict_way]),
        .set_rd_i(set_rd[evict_set]),
        .dirty_i (evict_dirty),
        .score_o (score_c),
        .copy_o  (copy_c)
    );

    dec_state_t state_q, state_d;
    logic               copy_q;
    logic [SCORE_W-1:0] score_q;
    logic               dirty_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DEC_IDLE: state_d = evict_valid ? DEC_EMIT : DEC_IDLE;
            DEC_EMIT: state_d = evict_valid ? DEC_EMIT : DEC_IDLE;
            default:  state_d = DEC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DEC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            copy_q  <= 1'b0;
            score_q <= '0;
            dirty_q <= 1'b0;
        end else if (evict_valid) begin
            copy_q  <= copy_c;
            score_q <= score_c;
            dirty_q <= evict_dirty;
        end
    end

    always_comb begin
        dec_valid = (state_q == DEC_EMIT);
        dec_copy  = dec_valid && copy_q;
        dec_score = score_q;
    end

    AST_DEC_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |=> dec_valid); // R7

    AST_DEC_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !evict_valid |=> !dec_valid); // R7

    AST_DIRTY_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dirty_q) |-> dec_copy); // R6

    AST_SCORE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> dec_score <= SCORE_W'(SCORE_MAX)); // R4

    AST_HIGH_SCORE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dirty_q && dec_score >= SCORE_W'(COPY_THRESH)) |-> !dec_copy); // R5

endmodule

// File: tb/clean_copyback_predictor_tb_top.sv
`timescale 1ns/1ps
module clean_copyback_predictor_tb_top;

    localparam logic [1:0] K_HIT  = 2'd0;
    localparam logic [1:0] K_MISS = 2'd1;
    localparam logic [1:0] K_FILL = 2'd2;
    localparam logic [1:0] K_NONE = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_valid;
    logic [1:0] acc_kind;
    logic [3:0] acc_set;
    logic [1:0] acc_way;
    logic       acc_prefetch;
    logic       evict_valid;
    logic [3:0] evict_set;
    logic [1:0] evict_way;
    logic       evict_dirty;
    logic       dec_valid;
    logic       dec_copy;
    logic [3:0] dec_score;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clean_copyback_predictor dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_set(acc_set),
        .acc_way(acc_way), .acc_prefetch(acc_prefetch),
        .evict_valid(evict_valid), .evict_set(evict_set),
        .evict_way(evict_way), .evict_dirty(evict_dirty),
        .dec_valid(dec_valid), .dec_copy(dec_copy), .dec_score(dec_score)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        acc_valid = 1'b0; acc_kind = K_NONE; acc_set = '0; acc_way = '0;
        acc_prefetch = 1'b0; evict_valid = 1'b0; evict_set = '0;
        evict_way = '0; evict_dirty = 1'b0;
    endtask

    task automatic put_acc(input logic [1:0] k, input int s, input int w, input bit pf);
        acc_valid = 1'b1; acc_kind = k; acc_set = 4'(s);
        acc_way = 2'(w); acc_prefetch = pf;
    endtask

    task automatic put_evict(input int s, input int w, input bit dirty);
        evict_valid = 1'b1; evict_set = 4'(s);
        evict_way = 2'(w); evict_dirty = dirty;
    endtask

    task automatic acc(input logic [1:0] k, input int s, input int w, input bit pf);
        put_acc(k, s, w, pf);
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic misses(input int s, input int n);
        for (int i = 0; i < n; i++) acc(K_MISS, s, 0, 1'b0);
    endtask

    task automatic expect_dec(input string tag, input int score, input bit copy);
        chk({tag, " dec_valid"}, int'(dec_valid), 1);
        chk({tag, " dec_score"}, int'(dec_score), score);
        chk({tag, " dec_copy"},  int'(dec_copy), int'(copy));
    endtask

    task automatic evict(input string tag, input int s, input int w, input bit dirty,
                         input int score, input bit copy);
        put_evict(s, w, dirty);
        @(negedge clk);
        clear_inputs();
        expect_dec(tag, score, copy);
    endtask

    task automatic t_reset();
        clear_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 dec_valid after reset", int'(dec_valid), 0);
        evict("R9 R4 untouched line", 3, 0, 1'b0, 5, 1'b1);
        @(negedge clk);
        chk("R7 strobe lasts one cycle", int'(dec_valid), 0);
    endtask

    task automatic t_prefetch_stream();
        acc(K_FILL, 1, 0, 1'b1);
        misses(1, 3);
        evict("R4 R5 prefetched far line dropped", 1, 0, 1'b0, 14, 1'b0);
        evict("R6 dirty high score copied", 1, 0, 1'b1, 14, 1'b1);
        chk("R7 back-to-back still valid", int'(dec_valid), 1);
    endtask

    task automatic t_hit_counter();
        acc(K_FILL, 2, 1, 1'b0);
        acc(K_HIT, 2, 1, 1'b0);
        acc(K_HIT, 2, 1, 1'b0);
        evict("R2 two hits", 2, 1, 1'b0, 4, 1'b1);
        acc(K_FILL, 2, 1, 1'b0);
        for (int i = 0; i < 5; i++) acc(K_HIT, 2, 1, 1'b0);
        evict("R2 hit counter saturates", 2, 1, 1'b0, 4, 1'b1);
        acc(K_FILL, 2, 1, 1'b0);
        evict("R2 fill clears hits", 2, 1, 1'b0, 5, 1'b1);
    endtask

    task automatic t_threshold();
        acc(K_FILL, 6, 0, 1'b0);
        acc(K_HIT, 6, 0, 1'b0);
        acc(K_HIT, 6, 0, 1'b0);
        acc(K_MISS, 6, 0, 1'b0);
        evict("R5 score 12 dropped", 6, 0, 1'b0, 12, 1'b0);
        acc(K_FILL, 7, 2, 1'b1);
        evict("R5 score 6 copied", 7, 2, 1'b0, 6, 1'b1);
    endtask

    task automatic t_epoch_and_overlap();
        acc(K_FILL, 5, 0, 1'b0);
        acc(K_FILL, 5, 1, 1'b0);
        for (int i = 0; i < 7; i++) begin
            misses(5, 2);
            acc(K_HIT, 5, 1, 1'b0);
        end
        misses(5, 2);
        acc(K_FILL, 5, 3, 1'b0);
        misses(5, 2);
        evict("R3 set distance unchanged before 8th hit", 5, 3, 1'b0, 13, 1'b0);
        acc(K_HIT, 5, 1, 1'b0);
        evict("R1 R3 saturated line vs set distance 2", 5, 0, 1'b0, 13, 1'b0);
        acc(K_FILL, 5, 2, 1'b0);
        acc(K_FILL, 5, 3, 1'b0);
        misses(5, 4);
        evict("R4 distance equals twice set distance", 5, 2, 1'b0, 5, 1'b1);
        misses(5, 2);
        put_acc(K_MISS, 5, 0, 1'b0);
        put_evict(5, 3, 1'b0);
        @(negedge clk);
        clear_inputs();
        expect_dec("R8 concurrent miss scored pre-update", 5, 1'b1);
        evict("R8 invalid line frozen", 5, 2, 1'b0, 5, 1'b1);
        acc(K_FILL, 5, 2, 1'b1);
        misses(5, 7);
        evict("R1 fill cleared then above thrice", 5, 2, 1'b0, 14, 1'b0);
        acc(K_FILL, 5, 2, 1'b0);
        misses(5, 7);
        put_acc(K_FILL, 5, 2, 1'b0);
        put_evict(5, 2, 1'b0);
        @(negedge clk);
        clear_inputs();
        expect_dec("R8 concurrent fill scored old metadata", 13, 1'b0);
        misses(5, 5);
        evict("R8 fill wins over invalidation", 5, 2, 1'b0, 5, 1'b1);
        @(negedge clk);
        chk("R7 idle after last request", int'(dec_valid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL R7 watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_prefetch_stream();
        t_hit_counter();
        t_threshold();
        t_epoch_and_overlap();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule